// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block lets a counter be driven by a trigger that comes from another timer. A trigger-select field picks one of a fixed list of external trigger inputs. Each input passes through its own synchronizer and rising-edge detector. A slave-mode field then decides how the chosen trigger acts on the counter:

- **No effect.** The counter runs only from the software enable bit.
- **Gating.** The trigger gates the count while it is high.
- **Hardware start.** A trigger edge sets the enable bit in hardware.
- **Count clock.** Each trigger edge advances the counter by one step.

The block drives two signals into an internal up-counter that wraps at a reload value:

- a count-enable qualifier;
- a count-tick strobe.

The counter steps on any cycle where both signals are high. Software sets and clears the enable bit with single-cycle pulses, and reads back the enable bit and the counter value directly. Encoder counting, input filtering and trigger polarity are not part of this block.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the counter value is 0 and the enable bit is 0. The count qualifier is 0 in every mode until the enable bit is set.
- R2: The trigger-select value 0 to 3 is the index of the chosen bit of `trig_in`. Activity on the other inputs has no effect on the counter or on the enable bit.
- R3: Each trigger input passes through two synchronizing flip-flops and then a rising-edge detector. In hardware-start mode, an input that rises before clock edge N shows as the enable bit set after edge N+2.
- R4: Slave-mode code 0 disables slave control. The counter advances by one on every cycle while the enable bit is set, and trigger inputs are ignored.
- R5: Slave-mode code 3 (reserved for encoder counting) and the unused codes 1, 2 and 4 behave exactly like code 0.
- R6: Slave-mode code 5 is gated mode. With the enable bit set, the counter advances once per cycle while the synchronized selected trigger is high. It holds its value while the trigger is low, and resumes from that held value without clearing.
- R7: Slave-mode code 6 is hardware-start mode. A rising edge of the selected trigger sets the enable bit. Further edges while the bit is set change neither the bit nor the count. A software clear stops the count, and the value then holds.
- R8: Slave-mode code 7 is trigger-clock mode. With the enable bit set, each rising edge of the selected trigger advances the counter by exactly one step.
- R9: In every mode, a step taken from the reload value makes the counter 0; any other step adds 1.
- R10: `sw_en_set` sets the enable bit and `sw_en_clr` clears it. When both are high in the same cycle, the clear wins.
- R11: The counter steps exactly on cycles where `count_qual` and `count_tick` are both 1, and holds on all other cycles. In code 7, `count_tick` is 0 except on a detected edge. In gated mode with the trigger low, `count_qual` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 2**TSEL_W | External trigger inputs, asynchronous |
| trig_sel | input | TSEL_W | Index of the selected trigger input |
| slave_mode | input | 3 | Slave-mode code (0, 3, 5, 6, 7 defined) |
| sw_en_set | input | 1 | Pulse that sets the enable bit |
| sw_en_clr | input | 1 | Pulse that clears the enable bit (priority) |
| reload | input | CNT_W | Last value before the counter wraps to 0 |
| cnt_en | output | 1 | Enable bit readback |
| cnt_value | output | CNT_W | Counter value readback |
| count_qual | output | 1 | Count-enable qualifier to the counter |
| count_tick | output | 1 | Count-tick strobe to the counter |

## Verification
Each mode is run with the same three input patterns:

- pulse trains on the selected input;
- the same trains on an input that is not selected;
- runs with and without the software enable.

The final count then tells the modes apart:

| Mode | Final count after two 3-cycle pulses |
|---|---|
| Disabled (code 0) | elapsed cycles |
| Gated (code 5) | 6 |
| Trigger-clock (code 7) | one per edge |
| Not enabled | 0 |

Hardware-start mode counts from the first edge. Its run shows that the second edge neither restarts the count nor adds to it.

A small reload value makes the count wrap, which shows the wrap rule in each mode. Directed steps cover three further points: the exact cycle at which a synchronized edge sets the enable bit, a set and a clear in the same cycle, and how the qualifier and tick split.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   // Slave-mode codes; the numeric values are decoded by the mode control
   typedef enum logic [2:0] {
      SM_OFF       = 3'd0,
      SM_ENCODER   = 3'd3,
      SM_GATED     = 3'd5,
      SM_TRIGGERED = 3'd6,
      SM_EXTCLK    = 3'd7
   } slave_mode_e;

   localparam int MODE_W = 3;

endpackage

// File: rtl/tsc_trig_sync.sv
// Per-input synchronizer bank with rising-edge detection.
module tsc_trig_sync #(
   parameter int NUM_IN      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] raw_in,
   output logic [NUM_IN-1:0] lvl_out,
   output logic [NUM_IN-1:0] rise_out
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("tsc_trig_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IN; gi++) begin : g_lane
         logic [SYNC_STAGES-1:0] chain_q;
         logic                   last_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
               last_q  <= 1'b0;
            end else begin
               chain_q <= {chain_q[SYNC_STAGES-2:0], raw_in[gi]};
               last_q  <= chain_q[SYNC_STAGES-1];
            end
         end

         assign lvl_out[gi]  = chain_q[SYNC_STAGES-1];
         assign rise_out[gi] = chain_q[SYNC_STAGES-1] & ~last_q;

         // R3
         edge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_out[gi] |=> !rise_out[gi]);
      end
   endgenerate

endmodule

// File: rtl/tsc_mode_ctrl.sv
// Enable bit and slave-mode decode into qualifier and tick.
module tsc_mode_ctrl
   import tsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              trig_lvl,
   input  logic              trig_rise,
   input  logic              sw_set,
   input  logic              sw_clr,
   output logic              en_q,
   output logic              qual,
   output logic              tick
);

   logic en_d;

   always_comb begin
      en_d = en_q;
      if (sw_clr)
         en_d = 1'b0;
      else if (sw_set)
         en_d = 1'b1;
      else if (mode == SM_TRIGGERED && trig_rise)
         en_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
   end

   always_comb begin
      qual = en_q;
      tick = 1'b1;
      case (mode)
         SM_GATED:  qual = en_q & trig_lvl;
         SM_EXTCLK: tick = trig_rise;
         default:   ;
      endcase
   end

   // R10
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> !en_q);

   // R7
   hw_start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SM_TRIGGERED && trig_rise && !sw_clr) |=> en_q);

endmodule

// File: rtl/tsc_counter.sv
// Up-counter that wraps to zero after the reload value.
module tsc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step)
         cnt_q <= (cnt_q == reload) ? '0 : cnt_q + ONE;
   end

   // R9
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == reload) |=> cnt_q == '0);

   // R11
   hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_slave_ctrl.sv
// Timer slave-mode controller top.
module tmr_slave_ctrl
   import tsc_pkg::*;
#(
   parameter int TSEL_W      = 2,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<TSEL_W)-1:0]  trig_in,
   input  logic [TSEL_W-1:0]       trig_sel,
   input  logic [MODE_W-1:0]       slave_mode,
   input  logic                    sw_en_set,
   input  logic                    sw_en_clr,
   input  logic [CNT_W-1:0]        reload,
   output logic                    cnt_en,
   output logic [CNT_W-1:0]        cnt_value,
   output logic                    count_qual,
   output logic                    count_tick
);

   localparam int NUM_TRIG = 1 << TSEL_W;

   generate
      if (TSEL_W < 1 || TSEL_W > 4) begin : g_bad_sel
         $error("tmr_slave_ctrl: TSEL_W out of range");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tmr_slave_ctrl: CNT_W must be at least 2");
      end
   endgenerate

   logic [NUM_TRIG-1:0] lvl_vec;
   logic [NUM_TRIG-1:0] rise_vec;
   logic                sel_lvl;
   logic                sel_rise;
   logic                step;

   tsc_trig_sync #(
      .NUM_IN      (NUM_TRIG),
      .SYNC_STAGES (SYNC_STAGES)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (trig_in),
      .lvl_out  (lvl_vec),
      .rise_out (rise_vec)
   );

   assign sel_lvl  = lvl_vec[trig_sel];
   assign sel_rise = rise_vec[trig_sel];

   tsc_mode_ctrl mode_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (slave_mode),
      .trig_lvl  (sel_lvl),
      .trig_rise (sel_rise),
      .sw_set    (sw_en_set),
      .sw_clr    (sw_en_clr),
      .en_q      (cnt_en),
      .qual      (count_qual),
      .tick      (count_tick)
   );

   assign step = count_qual & count_tick;

   tsc_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .reload (reload),
      .cnt_q  (cnt_value)
   );

   // R6
   gate_low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode == SM_GATED && !sel_lvl) |=> $stable(cnt_value));

   // R8
   extclk_no_edge_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode == SM_EXTCLK && !sel_rise) |=> $stable(cnt_value));

   // R1
   disabled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_value));

endmodule

// File: tb/tmr_slave_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_slave_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  trig_in = '0;
   logic [1:0]  trig_sel = '0;
   logic [2:0]  slave_mode = '0;
   logic        sw_en_set = 1'b0;
   logic        sw_en_clr = 1'b0;
   logic [15:0] reload = 16'd31;
   logic        cnt_en;
   logic [15:0] cnt_value;
   logic        count_qual;
   logic        count_tick;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tmr_slave_ctrl #(.TSEL_W(2), .CNT_W(16), .SYNC_STAGES(2)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_in    (trig_in),
      .trig_sel   (trig_sel),
      .slave_mode (slave_mode),
      .sw_en_set  (sw_en_set),
      .sw_en_clr  (sw_en_clr),
      .reload     (reload),
      .cnt_en     (cnt_en),
      .cnt_value  (cnt_value),
      .count_qual (count_qual),
      .count_tick (count_tick)
   );

   typedef struct packed {
      logic [2:0]  mode;
      logic [1:0]  sel;
      logic [1:0]  din;
      logic        sw;
      logic [2:0]  np;
      logic [2:0]  hi;
      logic [2:0]  lo;
      logic [15:0] rld;
      logic [15:0] exp;
   } row_t;

   localparam int NROWS = 16;
   // mode, sel, driven input, sw set, pulses, high, low, reload, expected count
   localparam row_t TBL [NROWS] = '{
      '{3'd0, 2'd0, 2'd0, 1'b1, 3'd0, 3'd3, 3'd3, 16'd31, 16'd5},
      '{3'd0, 2'd1, 2'd1, 1'b1, 3'd2, 3'd3, 3'd3, 16'd31, 16'd17},
      '{3'd0, 2'd2, 2'd2, 1'b1, 3'd2, 3'd3, 3'd3, 16'd7,  16'd1},
      '{3'd3, 2'd3, 2'd3, 1'b1, 3'd2, 3'd3, 3'd3, 16'd31, 16'd17},
      '{3'd3, 2'd0, 2'd0, 1'b0, 3'd2, 3'd3, 3'd3, 16'd31, 16'd0},
      '{3'd5, 2'd1, 2'd1, 1'b1, 3'd2, 3'd3, 3'd3, 16'd31, 16'd6},
      '{3'd5, 2'd2, 2'd3, 1'b1, 3'd2, 3'd3, 3'd3, 16'd31, 16'd0},
      '{3'd5, 2'd0, 2'd0, 1'b0, 3'd2, 3'd3, 3'd3, 16'd31, 16'd0},
      '{3'd6, 2'd3, 2'd3, 1'b0, 3'd2, 3'd3, 3'd3, 16'd31, 16'd14},
      '{3'd6, 2'd0, 2'd1, 1'b0, 3'd2, 3'd3, 3'd3, 16'd31, 16'd0},
      '{3'd6, 2'd2, 2'd2, 1'b0, 3'd2, 3'd3, 3'd3, 16'd7,  16'd6},
      '{3'd7, 2'd1, 2'd1, 1'b1, 3'd3, 3'd2, 3'd2, 16'd7,  16'd3},
      '{3'd7, 2'd3, 2'd3, 1'b1, 3'd3, 3'd2, 3'd2, 16'd1,  16'd1},
      '{3'd7, 2'd0, 2'd2, 1'b1, 3'd3, 3'd2, 3'd2, 16'd7,  16'd0},
      '{3'd7, 2'd2, 2'd2, 1'b0, 3'd3, 3'd2, 3'd2, 16'd7,  16'd0},
      '{3'd4, 2'd1, 2'd1, 1'b1, 3'd2, 3'd3, 3'd3, 16'd31, 16'd17}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic string mode_tag(input logic [2:0] m);
      case (m)
         3'd5:    return "R6";
         3'd6:    return "R7";
         3'd7:    return "R8";
         3'd0:    return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic start_reset(input logic [2:0] m, input logic [1:0] s,
                              input logic [15:0] r);
      rst_n = 1'b0;
      trig_in = '0;
      sw_en_set = 1'b0;
      sw_en_clr = 1'b0;
      slave_mode = m;
      trig_sel = s;
      reload = r;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Row timeline: enable set at release, pulses, settle, then a clear pulse
   task automatic run_row(input int idx);
      row_t v;
      v = TBL[idx];
      start_reset(v.mode, v.sel, v.rld);
      sw_en_set = v.sw;
      @(negedge clk);
      sw_en_set = 1'b0;
      for (int p = 0; p < int'(v.np); p++) begin
         trig_in[v.din] = 1'b1;
         repeat (int'(v.hi)) @(negedge clk);
         trig_in[v.din] = 1'b0;
         repeat (int'(v.lo)) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      sw_en_clr = 1'b1;
      @(negedge clk);
      sw_en_clr = 1'b0;
      repeat (3) @(negedge clk);
      // R2 rows drive an unselected input; R9 rows use a small reload
      chk(cnt_value == v.exp, mode_tag(v.mode), $sformatf("row %0d count", idx),
          cnt_value, v.exp);
      chk(cnt_en == 1'b0, "R10", $sformatf("row %0d enable after clear", idx),
          cnt_en, 0);
   endtask

   initial begin
      int c;
      // R1 reset state
      start_reset(3'd0, 2'd0, 16'd31);
      chk(cnt_value == 16'd0, "R1", "count after reset", cnt_value, 0);
      chk(cnt_en == 1'b0, "R1", "enable after reset", cnt_en, 0);
      chk(count_qual == 1'b0, "R1", "qualifier after reset", count_qual, 0);
      repeat (5) @(negedge clk);
      chk(cnt_value == 16'd0, "R1", "count idle", cnt_value, 0);

      for (int i = 0; i < NROWS; i++) run_row(i);

      // R3 / R7 timing of hardware start, extra edge ignored, clear stops
      start_reset(3'd6, 2'd2, 16'd1000);
      trig_in[2] = 1'b1;                       // negedge 0
      repeat (2) @(negedge clk);               // negedge 2
      chk(cnt_en == 1'b0, "R3", "enable two edges after input", cnt_en, 0);
      @(negedge clk);                          // negedge 3
      chk(cnt_en == 1'b1, "R3", "enable three edges after input", cnt_en, 1);
      trig_in[2] = 1'b0;
      repeat (3) @(negedge clk);               // negedge 6
      trig_in[2] = 1'b1;
      repeat (6) @(negedge clk);               // negedge 12
      chk(cnt_value == 16'd9, "R7", "count unaffected by second edge", cnt_value, 9);
      sw_en_clr = 1'b1;
      @(negedge clk);
      sw_en_clr = 1'b0;
      c = cnt_value;
      repeat (5) @(negedge clk);
      chk(cnt_value == 16'(c), "R7", "count holds after clear", cnt_value, c);
      chk(cnt_en == 1'b0, "R7", "enable after clear", cnt_en, 0);
      trig_in[2] = 1'b0;
      repeat (2) @(negedge clk);
      trig_in[2] = 1'b1;
      repeat (3) @(negedge clk);
      chk(cnt_en == 1'b1, "R7", "new edge restarts", cnt_en, 1);

      // R10 set and clear together
      start_reset(3'd0, 2'd0, 16'd31);
      sw_en_set = 1'b1;
      sw_en_clr = 1'b1;
      @(negedge clk);
      sw_en_set = 1'b0;
      sw_en_clr = 1'b0;
      chk(cnt_en == 1'b0, "R10", "clear wins over set", cnt_en, 0);
      repeat (3) @(negedge clk);
      chk(cnt_value == 16'd0, "R10", "no count after tie", cnt_value, 0);

      // R9 wrap sequence in disabled mode
      start_reset(3'd0, 2'd0, 16'd3);
      sw_en_set = 1'b1;                        // negedge 0
      @(negedge clk);
      sw_en_set = 1'b0;
      repeat (3) @(negedge clk);               // negedge 4
      chk(cnt_value == 16'd3, "R9", "count at reload", cnt_value, 3);
      @(negedge clk);
      chk(cnt_value == 16'd0, "R9", "count wraps to zero", cnt_value, 0);

      // R11 qualifier and tick split
      slave_mode = 3'd7;
      #1;
      chk(count_qual == 1'b1 && count_tick == 1'b0, "R11", "extclk idle qual/tick",
          {count_qual, count_tick}, 2);
      slave_mode = 3'd5;
      #1;
      chk(count_qual == 1'b0 && count_tick == 1'b1, "R11", "gated low qual/tick",
          {count_qual, count_tick}, 1);
      c = cnt_value;
      repeat (3) @(negedge clk);
      chk(cnt_value == 16'(c), "R6", "gated low holds", cnt_value, c);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule